// File: doc/BRIEF.md
# Single-Precision Floating-Point Adder

This block adds two binary32 floating-point numbers in a three-stage pipeline and accepts one new operand pair every clock. The first stage unpacks both words, sorts them by magnitude and shifts the smaller significand right to line up the binary points. While it does so, it keeps guard, round and sticky bits. The second stage adds or subtracts the aligned significands and normalises the raw sum. It shifts right on a carry out, or shifts left by the leading-zero count after cancellation. The third stage rounds to nearest with ties to even. If rounding carries out of the significand, it normalises once more. It then checks the exponent against the normal range.

Normal numbers and zero are handled. Any input with a zero exponent field counts as zero, whatever its fraction bits hold. Results that fall below the smallest normal number flush to +0 and raise an underflow flag. Results whose exponent exceeds the largest normal exponent become a signed infinity and raise an overflow flag. Only round-to-nearest-even is provided.

Top module: `fp_add_pipe`

## Requirements
- R1: Operands and result use bit 31 as sign, bits 30..23 as an exponent biased by 127, and bits 22..0 as the fraction of an implied leading 1; for example -2.0 + -3.0 gives 0xC0A00000 and -1.0 + 0.25 gives 0xBF400000.
- R2: A result, with its flags, appears on the outputs with out_vld high exactly three rising edges after the edge that samples in_vld high. out_vld is low in every other cycle, and a new pair may enter on every cycle.
- R3: The operand with the smaller magnitude is shifted right by the exponent difference, and the bits shifted out survive as guard, round and sticky. A difference wider than the datapath leaves only a sticky bit, so 1.0 + 2^-126 gives 0x3F800000.
- R4: When the signs differ, the magnitudes are subtracted and the result takes the sign of the larger magnitude, regardless of operand order. An exact zero sum is +0 (0x00000000).
- R5: A carry out of the significand sum shifts the sum right by one and raises the exponent by one (1.0 + 1.0 = 0x40000000). Cancellation shifts left by the leading-zero count and lowers the exponent by the same count (0x3F800001 - 1.0 = 0x34000000).
- R6: Rounding is to nearest with ties to even. A tie keeps an even last bit (0x3F800000 + 0x33800000 = 0x3F800000) and rounds an odd one up (0x3F800001 + 0x33800000 = 0x3F800002). Anything above half an ulp rounds up.
- R7: When rounding carries out of the significand, the result is normalised again with the exponent raised by one. So 0x3FFFFFFF + 0x33800000 gives 0x40000000, and a carry past the top exponent overflows.
- R8: An input whose exponent field is zero is taken as zero, and its fraction bits have no effect. 0x00123456 + 3.0 gives 0x40400000, and -0 + +0 gives +0.
- R9: A result exponent of 255 or more gives infinity with the result's sign: 0x7F800000 or 0xFF800000. The overflow flag (out_ovf) is set.
- R10: A non-zero result whose exponent would be 0 or less gives 0x00000000 with the underflow flag (out_unf) set. A result exactly at the smallest normal exponent is returned normally with no flag.
- R11: While reset is asserted and until the first valid pair leaves the pipeline, out_vld, out_ovf, out_unf and out_sum are all zero. Pairs in flight when reset is asserted never produce out_vld.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released through an internal two-flop synchroniser |
| in_vld | input | 1 | Operand pair on in_a and in_b is valid this cycle |
| in_a | input | 32 | First binary32 operand |
| in_b | input | 32 | Second binary32 operand |
| out_vld | output | 1 | Result and flags are valid this cycle |
| out_sum | output | 32 | Rounded binary32 sum |
| out_ovf | output | 1 | Exponent overflow; out_sum holds a signed infinity |
| out_unf | output | 1 | Result below the normal range; out_sum holds +0 |

## Verification
Every result and both flags are due on the third rising edge after their pair is sampled, so the stream of table vectors is checked with a fixed three-cycle offset. The bench drives a new pair at each falling edge. At the same falling edge it checks the outputs for the pair driven three falling edges earlier. A separate single-pulse test checks that out_vld stays low one and two edges after the input edge, is high at the third, and is low again at the fourth. The reset tests sample the outputs at falling edges after the synchronised reset has settled.

// File: rtl/fpadd_pkg.sv
package fpadd_pkg;
  // guard, round and sticky bits carried below the significand
  localparam int unsigned GRS_W = 3;
  // extra bits that let an exponent go above range or below zero
  localparam int unsigned EXP_HEAD = 2;
endpackage

// File: rtl/fpa_align.sv
module fpa_align
  import fpadd_pkg::*;
#(
  parameter int unsigned EXP_W  = 8,
  parameter int unsigned FRAC_W = 23,
  localparam int unsigned EXT_W = FRAC_W + 1 + GRS_W,
  localparam int unsigned WORD_W = EXP_W + FRAC_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_vld,
  input  logic [WORD_W-1:0] op_a,
  input  logic [WORD_W-1:0] op_b,
  output logic              s1_vld,
  output logic              s1_sign,
  output logic              s1_sub,
  output logic [EXP_W-1:0]  s1_exp,
  output logic [EXT_W-1:0]  s1_big,
  output logic [EXT_W-1:0]  s1_small
);
  localparam int unsigned SIG_W = FRAC_W + 1;
  localparam int unsigned MAG_W = EXP_W + FRAC_W;
  localparam int unsigned SH_W  = $clog2(EXT_W + 1);

  logic [EXP_W-1:0]   exp_a, exp_b, exp_hi, exp_lo, exp_gap;
  logic               zero_a, zero_b, a_wins;
  logic [SIG_W-1:0]   sig_a, sig_b, sig_hi, sig_lo;
  logic [MAG_W-1:0]   mag_a, mag_b;
  logic [SH_W-1:0]    shamt;
  logic [2*EXT_W-1:0] spread;
  logic [EXT_W-1:0]   lo_aligned;
  logic               nxt_sign;

  always_comb begin
    exp_a  = op_a[MAG_W-1:FRAC_W];
    exp_b  = op_b[MAG_W-1:FRAC_W];
    zero_a = (exp_a == '0);
    zero_b = (exp_b == '0);
    sig_a  = zero_a ? '0 : {1'b1, op_a[FRAC_W-1:0]};
    sig_b  = zero_b ? '0 : {1'b1, op_b[FRAC_W-1:0]};
    mag_a  = zero_a ? '0 : op_a[MAG_W-1:0];
    mag_b  = zero_b ? '0 : op_b[MAG_W-1:0];
    a_wins = (mag_a >= mag_b);

    exp_hi   = a_wins ? exp_a : exp_b;
    exp_lo   = a_wins ? exp_b : exp_a;
    sig_hi   = a_wins ? sig_a : sig_b;
    sig_lo   = a_wins ? sig_b : sig_a;
    nxt_sign = a_wins ? op_a[WORD_W-1] : op_b[WORD_W-1];

    exp_gap = exp_hi - exp_lo;
    shamt   = (exp_gap > EXP_W'(EXT_W)) ? SH_W'(EXT_W) : SH_W'(exp_gap);
    spread  = {sig_lo, {GRS_W{1'b0}}, {EXT_W{1'b0}}} >> shamt;
    lo_aligned = spread[2*EXT_W-1:EXT_W]
               | {{(EXT_W-1){1'b0}}, |spread[EXT_W-1:0]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_vld   <= 1'b0;
      s1_sign  <= 1'b0;
      s1_sub   <= 1'b0;
      s1_exp   <= '0;
      s1_big   <= '0;
      s1_small <= '0;
    end else begin
      s1_vld <= in_vld;
      if (in_vld) begin
        s1_sign  <= nxt_sign;
        s1_sub   <= op_a[WORD_W-1] ^ op_b[WORD_W-1];
        s1_exp   <= exp_hi;
        s1_big   <= {sig_hi, {GRS_W{1'b0}}};
        s1_small <= lo_aligned;
      end
    end
  end

  // R3: after alignment the smaller operand never exceeds the larger one
  assert_align_order_R3 : assert property (@(posedge clk) disable iff (!rst_n)
    s1_vld |-> (s1_small <= s1_big));

endmodule

// File: rtl/fpa_norm.sv
module fpa_norm
  import fpadd_pkg::*;
#(
  parameter int unsigned EXP_W  = 8,
  parameter int unsigned FRAC_W = 23,
  localparam int unsigned EXT_W = FRAC_W + 1 + GRS_W,
  localparam int unsigned EW2   = EXP_W + EXP_HEAD
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             s1_vld,
  input  logic             s1_sign,
  input  logic             s1_sub,
  input  logic [EXP_W-1:0] s1_exp,
  input  logic [EXT_W-1:0] s1_big,
  input  logic [EXT_W-1:0] s1_small,
  output logic             s2_vld,
  output logic             s2_sign,
  output logic             s2_zero,
  output logic [EW2-1:0]   s2_exp,
  output logic [EXT_W-1:0] s2_sig
);
  localparam int unsigned LZ_W = $clog2(EXT_W);

  function automatic logic [LZ_W-1:0] count_lz(input logic [EXT_W-1:0] v);
    logic [LZ_W-1:0] n;
    n = '0;
    for (int i = 0; i < EXT_W; i++) begin
      if (v[i]) n = LZ_W'(EXT_W - 1 - i);
    end
    return n;
  endfunction

  logic [EXT_W:0]   raw;
  logic [LZ_W-1:0]  lz;
  logic             nxt_zero, nxt_sign;
  logic [EW2-1:0]   nxt_exp;
  logic [EXT_W-1:0] nxt_sig;

  always_comb begin
    raw = s1_sub ? ({1'b0, s1_big} - {1'b0, s1_small})
                 : ({1'b0, s1_big} + {1'b0, s1_small});
    lz       = count_lz(raw[EXT_W-1:0]);
    nxt_zero = (raw == '0);
    nxt_sign = s1_sign & ~nxt_zero;
    if (raw[EXT_W]) begin
      nxt_sig = raw[EXT_W:1] | {{(EXT_W-1){1'b0}}, raw[0]};
      nxt_exp = {{EXP_HEAD{1'b0}}, s1_exp} + EW2'(1);
    end else begin
      nxt_sig = raw[EXT_W-1:0] << lz;
      nxt_exp = {{EXP_HEAD{1'b0}}, s1_exp} - EW2'(lz);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s2_vld  <= 1'b0;
      s2_sign <= 1'b0;
      s2_zero <= 1'b0;
      s2_exp  <= '0;
      s2_sig  <= '0;
    end else begin
      s2_vld <= s1_vld;
      if (s1_vld) begin
        s2_sign <= nxt_sign;
        s2_zero <= nxt_zero;
        s2_exp  <= nxt_exp;
        s2_sig  <= nxt_sig;
      end
    end
  end

  // R5: every non-zero sum leaves this stage with its leading one at the top
  assert_norm_msb_R5 : assert property (@(posedge clk) disable iff (!rst_n)
    (s2_vld && !s2_zero) |-> s2_sig[EXT_W-1]);

  // R4: an exact zero sum is always positive
  assert_zero_plus_R4 : assert property (@(posedge clk) disable iff (!rst_n)
    (s2_vld && s2_zero) |-> !s2_sign);

endmodule

// File: rtl/fpa_round.sv
module fpa_round
  import fpadd_pkg::*;
#(
  parameter int unsigned EXP_W  = 8,
  parameter int unsigned FRAC_W = 23,
  localparam int unsigned EXT_W = FRAC_W + 1 + GRS_W,
  localparam int unsigned EW2   = EXP_W + EXP_HEAD,
  localparam int unsigned WORD_W = EXP_W + FRAC_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              s2_vld,
  input  logic              s2_sign,
  input  logic              s2_zero,
  input  logic [EW2-1:0]    s2_exp,
  input  logic [EXT_W-1:0]  s2_sig,
  output logic              out_vld,
  output logic [WORD_W-1:0] out_sum,
  output logic              out_ovf,
  output logic              out_unf
);
  localparam int unsigned SIG_W   = FRAC_W + 1;
  localparam int unsigned EXP_TOP = (1 << EXP_W) - 1;

  logic              lsb, grd, stk, bump;
  logic [SIG_W:0]    mant;
  logic [FRAC_W-1:0] frac_r;
  logic [EW2-1:0]    exp_r;
  logic [WORD_W-1:0] nxt_sum;
  logic              nxt_ovf, nxt_unf;

  always_comb begin
    lsb  = s2_sig[GRS_W];
    grd  = s2_sig[GRS_W-1];
    stk  = |s2_sig[GRS_W-2:0];
    bump = grd & (stk | lsb);
    mant = {1'b0, s2_sig[EXT_W-1:GRS_W]} + (SIG_W+1)'(bump);
    if (mant[SIG_W]) begin
      frac_r = mant[FRAC_W:1];
      exp_r  = s2_exp + EW2'(1);
    end else begin
      frac_r = mant[FRAC_W-1:0];
      exp_r  = s2_exp;
    end

    nxt_ovf = 1'b0;
    nxt_unf = 1'b0;
    if (s2_zero) begin
      nxt_sum = '0;
    end else if (exp_r[EW2-1] || exp_r == '0) begin
      nxt_sum = '0;
      nxt_unf = 1'b1;
    end else if (exp_r >= EW2'(EXP_TOP)) begin
      nxt_sum = {s2_sign, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
      nxt_ovf = 1'b1;
    end else begin
      nxt_sum = {s2_sign, exp_r[EXP_W-1:0], frac_r};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_vld <= 1'b0;
      out_sum <= '0;
      out_ovf <= 1'b0;
      out_unf <= 1'b0;
    end else begin
      out_vld <= s2_vld;
      if (s2_vld) begin
        out_sum <= nxt_sum;
        out_ovf <= nxt_ovf;
        out_unf <= nxt_unf;
      end
    end
  end

  // R9: the overflow flag always comes with an infinity encoding
  assert_ovf_inf_R9 : assert property (@(posedge clk) disable iff (!rst_n)
    (out_vld && out_ovf) |-> (out_sum[WORD_W-2:0] == {{EXP_W{1'b1}}, {FRAC_W{1'b0}}}));

  // R10: the underflow flag always comes with +0
  assert_unf_zero_R10 : assert property (@(posedge clk) disable iff (!rst_n)
    (out_vld && out_unf) |-> (out_sum == '0));

  // R7: a flag-free result never carries the reserved all-ones exponent
  assert_renorm_range_R7 : assert property (@(posedge clk) disable iff (!rst_n)
    (out_vld && !out_ovf) |-> (out_sum[WORD_W-2:FRAC_W] != {EXP_W{1'b1}}));

  // R9 / R10: never both flags at once
  assert_flag_excl_R10 : assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({out_ovf, out_unf}));

endmodule

// File: rtl/fp_add_pipe.sv
module fp_add_pipe
  import fpadd_pkg::*;
#(
  parameter int unsigned EXP_W  = 8,
  parameter int unsigned FRAC_W = 23
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      in_vld,
  input  logic [EXP_W+FRAC_W:0]     in_a,
  input  logic [EXP_W+FRAC_W:0]     in_b,
  output logic                      out_vld,
  output logic [EXP_W+FRAC_W:0]     out_sum,
  output logic                      out_ovf,
  output logic                      out_unf
);
  localparam int unsigned EXT_W = FRAC_W + 1 + GRS_W;
  localparam int unsigned EW2   = EXP_W + EXP_HEAD;

  // asynchronous assertion, synchronous release
  logic [1:0] rst_sync;
  logic       core_rst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign core_rst_n = rst_sync[1];

  logic             s1_vld, s1_sign, s1_sub;
  logic [EXP_W-1:0] s1_exp;
  logic [EXT_W-1:0] s1_big, s1_small;
  logic             s2_vld, s2_sign, s2_zero;
  logic [EW2-1:0]   s2_exp;
  logic [EXT_W-1:0] s2_sig;

  fpa_align #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) i_align (
    .clk(clk), .rst_n(core_rst_n), .in_vld(in_vld), .op_a(in_a), .op_b(in_b),
    .s1_vld(s1_vld), .s1_sign(s1_sign), .s1_sub(s1_sub), .s1_exp(s1_exp),
    .s1_big(s1_big), .s1_small(s1_small)
  );

  fpa_norm #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) i_norm (
    .clk(clk), .rst_n(core_rst_n), .s1_vld(s1_vld), .s1_sign(s1_sign),
    .s1_sub(s1_sub), .s1_exp(s1_exp), .s1_big(s1_big), .s1_small(s1_small),
    .s2_vld(s2_vld), .s2_sign(s2_sign), .s2_zero(s2_zero), .s2_exp(s2_exp),
    .s2_sig(s2_sig)
  );

  fpa_round #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) i_round (
    .clk(clk), .rst_n(core_rst_n), .s2_vld(s2_vld), .s2_sign(s2_sign),
    .s2_zero(s2_zero), .s2_exp(s2_exp), .s2_sig(s2_sig),
    .out_vld(out_vld), .out_sum(out_sum), .out_ovf(out_ovf), .out_unf(out_unf)
  );

  // R2: a result leaves exactly three edges after its pair entered
  assert_latency_R2 : assert property (@(posedge clk) disable iff (!core_rst_n)
    out_vld == $past(in_vld, 3));

endmodule

// File: tb/test_fp_add_pipe.sv
module test_fp_add_pipe;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_vld;
  logic [31:0] in_a, in_b;
  logic        out_vld;
  logic [31:0] out_sum;
  logic        out_ovf, out_unf;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  fp_add_pipe i_fp_add_pipe (
    .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_a(in_a), .in_b(in_b),
    .out_vld(out_vld), .out_sum(out_sum), .out_ovf(out_ovf), .out_unf(out_unf)
  );

  // {requirement number, a, b, expected sum, expected {ovf,unf}}
  localparam int NV = 22;
  localparam logic [105:0] VEC [NV] = '{
    {8'd5,  32'h3F800000, 32'h3F800000, 32'h40000000, 2'b00}, // R5 carry out
    {8'd1,  32'hC0000000, 32'hC0400000, 32'hC0A00000, 2'b00}, // R1 -5.0
    {8'd1,  32'hBF800000, 32'h3E800000, 32'hBF400000, 2'b00}, // R1 -0.75
    {8'd4,  32'h3E800000, 32'hBF800000, 32'hBF400000, 2'b00}, // R4 order swapped
    {8'd4,  32'h3F800000, 32'hBF800000, 32'h00000000, 2'b00}, // R4 exact zero
    {8'd4,  32'h40400000, 32'hC0800000, 32'hBF800000, 2'b00}, // R4 larger sign
    {8'd5,  32'h3F800001, 32'hBF800000, 32'h34000000, 2'b00}, // R5 cancellation
    {8'd3,  32'h40000000, 32'h3F800000, 32'h40400000, 2'b00}, // R3 one-place shift
    {8'd3,  32'h3F800000, 32'h00800000, 32'h3F800000, 2'b00}, // R3 sticky only
    {8'd7,  32'h3F800000, 32'h80800000, 32'h3F800000, 2'b00}, // R7 borrow rounds back
    {8'd6,  32'h3F800000, 32'h33800000, 32'h3F800000, 2'b00}, // R6 tie, even
    {8'd6,  32'h3F800001, 32'h33800000, 32'h3F800002, 2'b00}, // R6 tie, odd
    {8'd6,  32'h3F800000, 32'h33800001, 32'h3F800001, 2'b00}, // R6 above half
    {8'd7,  32'h3FFFFFFF, 32'h33800000, 32'h40000000, 2'b00}, // R7 round carry
    {8'd8,  32'h00123456, 32'h40400000, 32'h40400000, 2'b00}, // R8 fraction ignored
    {8'd8,  32'h80000000, 32'h00000000, 32'h00000000, 2'b00}, // R8 -0 + +0
    {8'd9,  32'h7F7FFFFF, 32'h7F7FFFFF, 32'h7F800000, 2'b10}, // R9 +inf
    {8'd9,  32'hFF7FFFFF, 32'hFF7FFFFF, 32'hFF800000, 2'b10}, // R9 -inf
    {8'd9,  32'h7F7FFFFF, 32'h73000000, 32'h7F800000, 2'b10}, // R9 via rounding
    {8'd10, 32'h00800001, 32'h80800000, 32'h00000000, 2'b01}, // R10 flush
    {8'd10, 32'h00800000, 32'h00800000, 32'h01000000, 2'b00}, // R10 boundary
    {8'd10, 32'h00C00000, 32'h80800000, 32'h00000000, 2'b01}  // R10 half of min
  };

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic check_outputs(input int idx);
    logic [105:0] v;
    string req;
    v = VEC[idx];
    req = $sformatf("R%0d", v[105:98]);
    check("R2", $sformatf("vec%0d out_vld", idx), 32'(out_vld), 32'd1);
    check(req, $sformatf("vec%0d sum", idx), out_sum, v[33:2]);
    check(req, $sformatf("vec%0d flags", idx), 32'({out_ovf, out_unf}), 32'(v[1:0]));
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R2 watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n  = 1'b0;
    in_vld = 1'b0;
    in_a   = '0;
    in_b   = '0;
    repeat (3) @(negedge clk);
    // R11: outputs idle during reset
    check("R11", "out_vld in reset", 32'(out_vld), 32'd0);
    check("R11", "out_sum in reset", out_sum, 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R11", "out_vld after reset", 32'(out_vld), 32'd0);
    check("R11", "flags after reset", 32'({out_ovf, out_unf}), 32'd0);
    check("R11", "out_sum after reset", out_sum, 32'd0);

    // streaming table: one pair per cycle, results checked three cycles later
    for (int k = 0; k < NV + 3; k++) begin
      if (k >= 3) check_outputs(k - 3);
      if (k < NV) begin
        in_vld = 1'b1;
        in_a   = VEC[k][97:66];
        in_b   = VEC[k][65:34];
      end else begin
        in_vld = 1'b0;
      end
      @(negedge clk);
    end
    check("R2", "out_vld after stream", 32'(out_vld), 32'd0);

    // R2: single pulse latency
    repeat (2) @(negedge clk);
    in_vld = 1'b1; in_a = 32'h3F800000; in_b = 32'h40000000;
    @(negedge clk);
    in_vld = 1'b0;
    check("R2", "out_vld one edge", 32'(out_vld), 32'd0);
    @(negedge clk);
    check("R2", "out_vld two edges", 32'(out_vld), 32'd0);
    @(negedge clk);
    check("R2", "out_vld three edges", 32'(out_vld), 32'd1);
    check("R2", "pulse sum", out_sum, 32'h40400000);
    @(negedge clk);
    check("R2", "out_vld four edges", 32'(out_vld), 32'd0);

    // R11: pairs in flight are dropped by reset
    in_vld = 1'b1; in_a = 32'h40000000; in_b = 32'h40000000;
    @(negedge clk);
    in_vld = 1'b0;
    rst_n  = 1'b0;
    for (int c = 0; c < 4; c++) begin
      @(negedge clk);
      check("R11", $sformatf("out_vld flushed %0d", c), 32'(out_vld), 32'd0);
    end
    rst_n = 1'b1;
    for (int c = 0; c < 4; c++) begin
      @(negedge clk);
      check("R11", $sformatf("out_vld released %0d", c), 32'(out_vld), 32'd0);
    end
    check("R11", "out_sum after flush", out_sum, 32'd0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule